// File: doc/BRIEF.md
# PATA PIO Cycle Timing Generator

This block produces the read and write strobes for parallel ATA programmed-I/O cycles. It serves two channels, each with a master and a slave device, so it keeps four timing units. The unit index is the channel number times two plus the device number. Each unit owns a 16-bit timing word. The low byte times reads and the high byte times writes. Each byte packs an active-pulse length and a recovery length, both stored in complemented form. Each unit also has an enable bit. When the bit is set, the IORDY line is not sampled. This covers DMA-style operation and PIO to devices that do not need the handshake.

A request names a unit and a direction and is accepted only while the engine is idle. The engine drives the matching strobe for the decoded active length. If IORDY sampling applies to the unit, a low IORDY stretches the active phase. The engine then holds the strobe low for the decoded recovery length and raises a one-cycle done pulse before it takes the next request. While a write cycle is in flight, a busy flag for that channel's write buffer is reported. Timing and enable updates offered during that window are dropped, so they can only land while both flags are clear.

Top module: `pio_cycle_timer`

## Requirements
- R1: After an active-low synchronous reset, every timing word reads as 0x0000, which decodes as active 17 clocks and recovery 16 clocks. All enable bits are clear, both strobes are low, done is low, reqReady is high and wbBusy is 0.
- R2: A read request on unit u drives rdStrobe high for exactly 17 minus bits [3:0] of word u clocks. The first high cycle is the cycle after acceptance.
- R3: After the strobe falls, both strobes stay low for 16 minus the recovery nibble clocks. The recovery nibble is bits [7:4] for reads and bits [15:12] for writes. The done pulse follows directly after.
- R4: A write request times its active phase from bits [11:8] of the unit word, using the same complemented rule, and drives wrStrobe only. rdStrobe and wrStrobe are never high together.
- R5: Unit index equals 2*channel + device. A cfgWrEn write updates only the word of cfgUnit, and each unit keeps its own timing.
- R6: With the unit's enable bit clear, IORDY low when the minimum active count has elapsed keeps the strobe high clock by clock until IORDY is seen high. The active phase is never shorter than the programmed length.
- R7: Bit u of modeEn, written with modeWrEn, is the enable of unit u. With it set, IORDY is ignored and the active length is exactly the programmed one.
- R8: done is high for exactly one cycle after recovery. reqReady is low from the cycle after acceptance through the done cycle and is high again the cycle after done.
- R9: wbBusy[c] is high from the cycle after a write to a unit of channel c is accepted through its done cycle. It is low during read cycles and when idle.
- R10: cfgWrEn and modeWrEn have no effect while wbBusy is nonzero. They take effect while wbBusy is zero, including during a read cycle, without changing the cycle in flight.
- R11: cycUnit shows the unit of the cycle in flight and stays stable while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Cycle request |
| reqUnit | input | 2 | Unit index of the request |
| reqWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| reqReady | output | 1 | Engine idle, request accepted this cycle |
| iordy | input | 1 | Device ready line |
| cfgWrEn | input | 1 | Timing word write strobe |
| cfgUnit | input | 2 | Unit whose timing word is written |
| cfgWord | input | 16 | New timing word |
| modeWrEn | input | 1 | Enable bits write strobe |
| modeEn | input | 4 | New enable bits, bit u for unit u |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| cycUnit | output | 2 | Unit of the current cycle |
| done | output | 1 | One-cycle end-of-cycle pulse |
| wbBusy | output | 2 | Write buffer busy per channel |

## Verification
A wrong counter load or a swapped nibble shows up as a strobe or recovery window of the wrong length within one cycle of about forty clocks. A dropped IORDY hold shows up as a strobe that falls while IORDY is still low. A stale enable or timing word, or an update that should have been blocked, surfaces in the next cycle run on that unit. A busy flag tied to the wrong channel or direction is visible on wbBusy from the first active clock.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int CNT_W    = NIB_W + 1;
  localparam int ACT_BIAS = (1 << NIB_W) + 1;
  localparam int REC_BIAS = (1 << NIB_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  typedef struct packed {
    logic takeReq;
    logic startRecov;
    logic tick;
    logic cycleOn;
  } ctl_t;
endpackage

// File: rtl/pct_len_decode.sv
`timescale 1ns/1ps
module pct_len_decode #(
  parameter int NIB_W = 4,
  parameter int CNT_W = 5,
  parameter int BIAS  = 17
) (
  input  logic [NIB_W-1:0] nib,
  output logic [CNT_W-1:0] len
);
  always_comb len = CNT_W'(BIAS) - CNT_W'(nib);
endmodule

// File: rtl/pct_datapath.sv
`timescale 1ns/1ps
module pct_datapath
  import pct_pkg::*;
#(
  parameter int NUM_CHAN     = 2,
  parameter int DEV_PER_CHAN = 2,
  localparam int NUM_UNIT    = NUM_CHAN * DEV_PER_CHAN,
  localparam int UNIT_W      = $clog2(NUM_UNIT),
  localparam int DEV_W       = $clog2(DEV_PER_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [UNIT_W-1:0]   reqUnit,
  input  logic                reqWrite,
  input  logic                iordy,
  input  logic                cfgWrEn,
  input  logic [UNIT_W-1:0]   cfgUnit,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic                modeWrEn,
  input  logic [NUM_UNIT-1:0] modeEn,
  output logic                cntZero,
  output logic                holdIordy,
  output logic [UNIT_W-1:0]   curUnit,
  output logic                curWrite,
  output logic [NUM_CHAN-1:0] wbBusy
);
  logic [WORD_W-1:0]   wordQ [NUM_UNIT];
  logic [NUM_UNIT-1:0] enQ;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    recHold;
  logic                iordyUse;
  logic                cfgLock;

  logic [WORD_W-1:0]   selWord;
  logic [BYTE_W-1:0]   selByte;
  logic [CNT_W-1:0]    lens [2];

  always_comb begin
    selWord = wordQ[reqUnit];
    selByte = reqWrite ? selWord[WORD_W-1:BYTE_W] : selWord[BYTE_W-1:0];
  end

  // index 0 decodes the active nibble, index 1 the recovery nibble
  for (genvar g = 0; g < 2; g++) begin : g_dec
    pct_len_decode #(
      .NIB_W(NIB_W),
      .CNT_W(CNT_W),
      .BIAS (g == 0 ? ACT_BIAS : REC_BIAS)
    ) u_dec (
      .nib(selByte[g*NIB_W +: NIB_W]),
      .len(lens[g])
    );
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_busy
    assign wbBusy[c] = ctl.cycleOn && curWrite &&
                       ((curUnit >> DEV_W) == UNIT_W'(c));
  end

  assign cfgLock = |wbBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_UNIT; u++) wordQ[u] <= '0;
      enQ <= '0;
    end else if (!cfgLock) begin
      if (cfgWrEn) wordQ[cfgUnit] <= cfgWord;
      if (modeWrEn) enQ <= modeEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      recHold  <= '0;
      curUnit  <= '0;
      curWrite <= 1'b0;
      iordyUse <= 1'b0;
    end else if (ctl.takeReq) begin
      cnt      <= lens[0] - CNT_W'(1);
      recHold  <= lens[1];
      curUnit  <= reqUnit;
      curWrite <= reqWrite;
      iordyUse <= !enQ[reqUnit];
    end else if (ctl.startRecov) begin
      cnt <= recHold - CNT_W'(1);
    end else if (ctl.tick && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero   = (cnt == '0);
  assign holdIordy = iordyUse && !iordy;
endmodule

// File: rtl/pct_ctrl.sv
`timescale 1ns/1ps
module pct_ctrl
  import pct_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic cntZero,
  input  logic holdIordy,
  input  logic curWrite,
  output ctl_t ctl,
  output logic reqReady,
  output logic rdStrobe,
  output logic wrStrobe,
  output logic done
);
  state_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    ctl.cycleOn = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.takeReq = 1'b1;
        stateNxt    = ST_ACT;
      end
      ST_ACT: if (cntZero && !holdIordy) begin
        ctl.startRecov = 1'b1;
        stateNxt       = ST_REC;
      end else begin
        ctl.tick = 1'b1;
      end
      ST_REC: if (cntZero) stateNxt = ST_DONE;
              else ctl.tick = 1'b1;
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady = (state == ST_IDLE);
  assign rdStrobe = (state == ST_ACT) && !curWrite;
  assign wrStrobe = (state == ST_ACT) && curWrite;
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/pio_cycle_timer.sv
`timescale 1ns/1ps
module pio_cycle_timer
  import pct_pkg::*;
#(
  parameter int NUM_CHAN     = 2,
  parameter int DEV_PER_CHAN = 2,
  localparam int NUM_UNIT    = NUM_CHAN * DEV_PER_CHAN,
  localparam int UNIT_W      = $clog2(NUM_UNIT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [UNIT_W-1:0]   reqUnit,
  input  logic                reqWrite,
  output logic                reqReady,
  input  logic                iordy,
  input  logic                cfgWrEn,
  input  logic [UNIT_W-1:0]   cfgUnit,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic                modeWrEn,
  input  logic [NUM_UNIT-1:0] modeEn,
  output logic                rdStrobe,
  output logic                wrStrobe,
  output logic [UNIT_W-1:0]   cycUnit,
  output logic                done,
  output logic [NUM_CHAN-1:0] wbBusy
);
  ctl_t ctl;
  logic cntZero, holdIordy, curWrite;

  pct_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cntZero  (cntZero),
    .holdIordy(holdIordy),
    .curWrite (curWrite),
    .ctl      (ctl),
    .reqReady (reqReady),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .done     (done)
  );

  pct_datapath #(
    .NUM_CHAN    (NUM_CHAN),
    .DEV_PER_CHAN(DEV_PER_CHAN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqUnit  (reqUnit),
    .reqWrite (reqWrite),
    .iordy    (iordy),
    .cfgWrEn  (cfgWrEn),
    .cfgUnit  (cfgUnit),
    .cfgWord  (cfgWord),
    .modeWrEn (modeWrEn),
    .modeEn   (modeEn),
    .cntZero  (cntZero),
    .holdIordy(holdIordy),
    .curUnit  (cycUnit),
    .curWrite (curWrite),
    .wbBusy   (wbBusy)
  );
endmodule

// File: rtl/pct_checker.sv
`timescale 1ns/1ps
module pct_checker #(
  parameter int NUM_CHAN = 2,
  parameter int UNIT_W   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                rdStrobe,
  input logic                wrStrobe,
  input logic                done,
  input logic [UNIT_W-1:0]   cycUnit,
  input logic [NUM_CHAN-1:0] wbBusy
);
  logic       sOn;
  logic [5:0] runLen;
  assign sOn = rdStrobe | wrStrobe;

  always_ff @(posedge clk) begin
    if (!rstN)            runLen <= '0;
    else if (!sOn)        runLen <= '0;
    else if (runLen != '1) runLen <= runLen + 6'd1;
  end

  p_excl_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  p_min_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sOn) |-> runLen >= 6'd2);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (sOn && !reqReady));

  p_done_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqReady && !sOn);

  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wbBusy != '0) |-> (!rdStrobe && !reqReady && $onehot0(wbBusy)));

  p_unit_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sOn && $past(sOn)) |-> $stable(cycUnit));
endmodule

bind pio_cycle_timer pct_checker #(.NUM_CHAN(NUM_CHAN), .UNIT_W(UNIT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe),
  .done    (done),
  .cycUnit (cycUnit),
  .wbBusy  (wbBusy)
);

// File: tb/pio_cycle_timer_test.sv
`timescale 1ns/1ps
module pio_cycle_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqUnit = '0;
  logic        reqWrite = 1'b0;
  logic        reqReady;
  logic        iordy = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgUnit = '0;
  logic [15:0] cfgWord = '0;
  logic        modeWrEn = 1'b0;
  logic [3:0]  modeEn = '0;
  logic        rdStrobe, wrStrobe, done;
  logic [1:0]  cycUnit;
  logic [1:0]  wbBusy;

  int total = 0;
  int bad = 0;
  logic [15:0] mWord [4];
  logic [3:0]  mEn;

  always #2.5 clk = ~clk;

  pio_cycle_timer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUnit(reqUnit),
    .reqWrite(reqWrite), .reqReady(reqReady), .iordy(iordy),
    .cfgWrEn(cfgWrEn), .cfgUnit(cfgUnit), .cfgWord(cfgWord),
    .modeWrEn(modeWrEn), .modeEn(modeEn), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .cycUnit(cycUnit), .done(done), .wbBusy(wbBusy)
  );

  function automatic int actOf(input logic [7:0] b);
    return 17 - int'(b[3:0]);
  endfunction
  function automatic int recOf(input logic [7:0] b);
    return 16 - int'(b[7:4]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setWord(input logic [1:0] u, input logic [15:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgUnit = u; cfgWord = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mWord[u] = w;
  endtask

  task automatic setMode(input logic [3:0] e);
    @(negedge clk);
    modeWrEn = 1'b1; modeEn = e;
    @(negedge clk);
    modeWrEn = 1'b0;
    mEn = e;
  endtask

  // k: IORDY held low until sample k of the active phase (0 = high throughout)
  // poke: offer a timing/mode update on the first active clock
  task automatic runCycle(input logic [1:0] u, input bit wr, input int k,
                          input bit poke, input logic [15:0] pWord,
                          input logic [3:0] pMode);
    logic [7:0] b;
    int expA, expR, hi, rec, expBusy;
    b = wr ? mWord[u][15:8] : mWord[u][7:0];
    expA = actOf(b);
    expR = recOf(b);
    if (!mEn[u] && k > expA) expA = k;
    expBusy = wr ? (1 << u[1]) : 0;
    @(negedge clk);
    chk(reqReady == 1'b1, "R8 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqUnit = u; reqWrite = wr;
    iordy = (k == 0);
    @(negedge clk);
    reqValid = 1'b0;
    hi = 0;
    while ((wr ? wrStrobe : rdStrobe) && hi < 100) begin
      hi++;
      chk((wr ? rdStrobe : wrStrobe) == 1'b0, "R4 other strobe low", 1, 0);
      if (hi == 1) begin
        chk(cycUnit == u, "R11 cycUnit", int'(cycUnit), int'(u));
        chk(int'(wbBusy) == expBusy, "R9 wbBusy", int'(wbBusy), expBusy);
        chk(reqReady == 1'b0, "R8 ready low in cycle", int'(reqReady), 0);
        if (poke) begin
          cfgWrEn = 1'b1; cfgUnit = u; cfgWord = pWord;
          modeWrEn = 1'b1; modeEn = pMode;
        end
      end
      if (hi == 2) begin
        cfgWrEn = 1'b0; modeWrEn = 1'b0;
      end
      if (hi == k) iordy = 1'b1;
      @(negedge clk);
    end
    iordy = 1'b1; cfgWrEn = 1'b0; modeWrEn = 1'b0;
    chk(hi == expA, wr ? "R4 write active length" :
        (k > 0 ? "R6 R7 active length" : "R2 read active length"), hi, expA);
    rec = 0;
    while (!rdStrobe && !wrStrobe && !done && rec < 100) begin
      rec++;
      @(negedge clk);
    end
    chk(rec == expR, "R3 recovery length", rec, expR);
    chk(done == 1'b1 && reqReady == 1'b0, "R8 done pulse", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && reqReady == 1'b1, "R8 done single", int'(done), 0);
    if (poke && !wr) begin
      mWord[u] = pWord;
      mEn = pMode;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mWord[i] = 16'h0000;
    mEn = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdStrobe == 0 && wrStrobe == 0, "R1 strobes low", int'(rdStrobe | wrStrobe), 0);
    chk(done == 0, "R1 done low", int'(done), 0);
    chk(wbBusy == 0, "R1 wbBusy clear", int'(wbBusy), 0);
    chk(reqReady == 1, "R1 ready", int'(reqReady), 1);
    // R1 slowest default timing, IORDY high
    runCycle(2'd3, 1'b0, 0, 1'b0, '0, '0);
    runCycle(2'd2, 1'b1, 0, 1'b0, '0, '0);
    // R2/R3/R4 fastest and mixed encodings
    setWord(2'd0, 16'hFFFF);
    runCycle(2'd0, 1'b0, 0, 1'b0, '0, '0);
    runCycle(2'd0, 1'b1, 0, 1'b0, '0, '0);
    setWord(2'd1, 16'h3A5C);
    runCycle(2'd1, 1'b0, 0, 1'b0, '0, '0);
    runCycle(2'd1, 1'b1, 0, 1'b0, '0, '0);
    // R5 unit 0 unaffected by unit 1 write
    runCycle(2'd0, 1'b0, 0, 1'b0, '0, '0);
    // R6 IORDY stretch, enable clear
    runCycle(2'd1, 1'b0, 9, 1'b0, '0, '0);
    runCycle(2'd1, 1'b0, 3, 1'b0, '0, '0);
    // R7 enable set: IORDY ignored
    setMode(4'b0010);
    runCycle(2'd1, 1'b0, 20, 1'b0, '0, '0);
    runCycle(2'd0, 1'b1, 6, 1'b0, '0, '0);
    // R10 update during write is dropped, during read applied
    runCycle(2'd3, 1'b1, 0, 1'b1, 16'h8888, 4'b1111);
    runCycle(2'd3, 1'b0, 0, 1'b0, '0, '0);
    runCycle(2'd1, 1'b0, 20, 1'b0, '0, '0);
    runCycle(2'd3, 1'b0, 0, 1'b1, 16'hC4E6, 4'b1000);
    runCycle(2'd3, 1'b0, 12, 1'b0, '0, '0);
    runCycle(2'd3, 1'b1, 0, 1'b0, '0, '0);
    runCycle(2'd1, 1'b0, 8, 1'b0, '0, '0);
    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] ru;
      bit rw;
      int rk;
      ru = 2'($urandom_range(0, 3));
      rw = 1'($urandom_range(0, 1));
      rk = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 22)) : 0;
      if ($urandom_range(0, 2) == 0) setWord(ru, 16'($urandom()));
      if ($urandom_range(0, 4) == 0) setMode(4'($urandom()));
      if ($urandom_range(0, 5) == 0)
        runCycle(ru, rw, rk, 1'b1, 16'($urandom()), 4'($urandom()));
      else
        runCycle(ru, rw, rk, 1'b0, '0, '0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule